// File: doc/BRIEF.md
# Presettable Synchronous Decade/Binary Counter

The block is a small up-counter whose bits all change together on the rising clock edge. A build-time parameter picks its modulus: decimal (0 to 9) or full binary (0 to 2^WIDTH-1, which is 15 at the default width of 4). A second parameter picks how the active-low clear behaves. It can act on the next rising edge, or it can act at once and without a clock.

A parallel word can be preset with an active-low load strobe. Counting is gated by two enables. The first, `cnt_en_p`, only permits counting. The second, `cnt_en_t`, also permits counting and additionally qualifies the terminal-count flag `carry_out`. A stage's flag can therefore drive the `cnt_en_t` of the next stage, and any width of counter can be cascaded with no extra gates.

Each rising edge performs one of four operations, chosen in fixed priority:
- CLEAR when `clr_n` is low. This applies only to the synchronous-clear build; the asynchronous build clears directly.
- LOAD when `load_n` is low.
- COUNT when both enables are high.
- HOLD otherwise.

The transitions are:
- CLEAR goes to value 0.
- LOAD goes to `din`.
- COUNT goes to the successor of the current value. From the terminal value the successor is 0.
- HOLD keeps the current value.

Top module: `sync_preset_counter`

## Requirements
- R1: On a rising edge with `clr_n` and `load_n` high, `q` advances by one only when `cnt_en_p` and `cnt_en_t` are both high; otherwise `q` keeps its value.
- R2: `carry_out` is 1 exactly when `q` equals the terminal value (9 in decimal mode, 15 in binary mode at WIDTH 4) and `cnt_en_t` is 1; `cnt_en_p` has no effect on it.
- R3: With `clr_n` high and `load_n` low at a rising edge, `q` takes `din` on that edge whatever the enables are.
- R4: In the synchronous-clear build, `clr_n` low sets `q` to 0 on the next rising edge and leaves `q` unchanged before that edge.
- R5: In the asynchronous-clear build, `clr_n` low sets `q` to 0 at once, without a clock edge, and holds it at 0 while low.
- R6: Clear wins over load and over counting.
- R7: Load wins over counting when both enables are high.
- R8: A count from the terminal value goes to 0: 9 to 0 in decimal mode, 15 to 0 in binary mode.
- R9: In decimal mode a loaded value from 10 to 15 counts up by one per count edge until it passes 15 and reaches 0; `carry_out` stays low on those values.
- R10: The following sequence works. Clear. Preset to 7 (or to 12 in binary mode). Count 8, 9, 0, 1, 2, 3 (or 13, 14, 15, 0, 1, 2). Then drop either enable, and the count is inhibited.
- R11: In the synchronous-clear build, driving `clr_n` from a decode of `q` equal to 5 makes the sequence 0 to 5 and then back to 0 on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| clr_n | input | 1 | Active-low clear; synchronous or asynchronous per parameter |
| load_n | input | 1 | Active-low synchronous parallel load |
| din | input | WIDTH | Preset word |
| cnt_en_p | input | 1 | Count permit that does not affect the carry flag |
| cnt_en_t | input | 1 | Count permit that also enables the carry flag |
| q | output | WIDTH | Current count |
| carry_out | output | 1 | Terminal-count flag, qualified by `cnt_en_t` |

## Verification
The bench builds four copies side by side, one for each pairing of modulus (decimal and binary) and clear style (synchronous and asynchronous), all at WIDTH 4. The decimal copies bring within reach the out-of-range values 10 to 15 and the 9-to-0 wrap. The binary copies reach the 15-to-0 wrap. The asynchronous copies allow a check of `q` in the middle of a cycle, right after `clr_n` falls. The synchronous copies allow the same mid-cycle check to show that nothing has changed yet, and they also run the count-truncation loop fed back from `q`.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

    // Operation selected for the coming rising edge, lowest to highest priority
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_COUNT = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } cnt_op_e;

    // Terminal value of the count for a given width and modulus choice
    function automatic int unsigned term_of(input int unsigned width, input bit decade);
        if (decade)
            return 9;
        else
            return (1 << width) - 1;
    endfunction

endpackage

// File: rtl/cnt_op_decode.sv
module cnt_op_decode
    import cnt_pkg::*;
#(
    parameter bit SYNC_CLEAR = 1'b1
) (
    input  logic    clr_n,
    input  logic    load_n,
    input  logic    en_p,
    input  logic    en_t,
    output cnt_op_e op
);

    logic clr_req;

    generate
        if (SYNC_CLEAR) begin : g_sync_clr
            assign clr_req = ~clr_n;
        end else begin : g_async_clr
            // Asynchronous clear is handled directly at the register
            assign clr_req = 1'b0;
        end
    endgenerate

    always_comb begin
        if (clr_req)
            op = OP_CLEAR;
        else if (!load_n)
            op = OP_LOAD;
        else if (en_p && en_t)
            op = OP_COUNT;
        else
            op = OP_HOLD;
    end

endmodule

// File: rtl/cnt_next_value.sv
module cnt_next_value
    import cnt_pkg::*;
#(
    parameter int unsigned WIDTH  = 4,
    parameter bit          DECADE = 1'b1
) (
    input  cnt_op_e            op,
    input  logic [WIDTH-1:0]   cur,
    input  logic [WIDTH-1:0]   din,
    output logic [WIDTH-1:0]   nxt
);

    localparam logic [WIDTH-1:0] TERM = WIDTH'(term_of(WIDTH, DECADE));
    localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);

    logic [WIDTH-1:0] succ;

    // Successor: terminal value goes to 0; values past terminal (decimal
    // mode) keep incrementing and roll over naturally at the top of the range
    always_comb begin
        if (cur == TERM)
            succ = '0;
        else
            succ = cur + ONE;
    end

    always_comb begin
        unique case (op)
            OP_CLEAR: nxt = '0;
            OP_LOAD:  nxt = din;
            OP_COUNT: nxt = succ;
            OP_HOLD:  nxt = cur;
            default:  nxt = cur;
        endcase
    end

endmodule

// File: rtl/cnt_carry.sv
module cnt_carry
    import cnt_pkg::*;
#(
    parameter int unsigned WIDTH  = 4,
    parameter bit          DECADE = 1'b1
) (
    input  logic [WIDTH-1:0] cur,
    input  logic             en_t,
    output logic             carry
);

    localparam logic [WIDTH-1:0] TERM = WIDTH'(term_of(WIDTH, DECADE));

    always_comb begin
        carry = en_t && (cur == TERM);
    end

endmodule

// File: rtl/sync_preset_counter.sv
module sync_preset_counter
    import cnt_pkg::*;
#(
    parameter int unsigned WIDTH      = 4,
    parameter bit          DECADE     = 1'b1,
    parameter bit          SYNC_CLEAR = 1'b1
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             load_n,
    input  logic [WIDTH-1:0] din,
    input  logic             cnt_en_p,
    input  logic             cnt_en_t,
    output logic [WIDTH-1:0] q,
    output logic             carry_out
);

    cnt_op_e          op;
    logic [WIDTH-1:0] state_q;
    logic [WIDTH-1:0] state_d;
    logic             carry_w;

    cnt_op_decode #(
        .SYNC_CLEAR (SYNC_CLEAR)
    ) u_decode (
        .clr_n  (clr_n),
        .load_n (load_n),
        .en_p   (cnt_en_p),
        .en_t   (cnt_en_t),
        .op     (op)
    );

    cnt_next_value #(
        .WIDTH  (WIDTH),
        .DECADE (DECADE)
    ) u_next (
        .op  (op),
        .cur (state_q),
        .din (din),
        .nxt (state_d)
    );

    cnt_carry #(
        .WIDTH  (WIDTH),
        .DECADE (DECADE)
    ) u_carry (
        .cur   (state_q),
        .en_t  (cnt_en_t),
        .carry (carry_w)
    );

    // State register: clear style chosen at build time
    generate
        if (SYNC_CLEAR) begin : g_reg_sync
            always_ff @(posedge clk) begin
                state_q <= state_d;
            end
        end else begin : g_reg_async
            always_ff @(posedge clk or negedge clr_n) begin
                if (!clr_n)
                    state_q <= '0;
                else
                    state_q <= state_d;
            end
        end
    endgenerate

    // Outputs
    always_comb begin
        q         = state_q;
        carry_out = carry_w;
    end

endmodule

// File: rtl/sync_preset_counter_chk.sv
module sync_preset_counter_chk
    import cnt_pkg::*;
#(
    parameter int unsigned WIDTH  = 4,
    parameter bit          DECADE = 1'b1
) (
    input logic             clk,
    input logic             clr_n,
    input logic             load_n,
    input logic [WIDTH-1:0] din,
    input logic             cnt_en_p,
    input logic             cnt_en_t,
    input logic [WIDTH-1:0] q,
    input logic             carry_out
);

    localparam logic [WIDTH-1:0] TERM = WIDTH'(term_of(WIDTH, DECADE));

    function automatic logic [WIDTH-1:0] after_step(input logic [WIDTH-1:0] v);
        if (v == TERM)
            return '0;
        else
            return v + WIDTH'(1);
    endfunction

    AST_LOAD_TAKES_WORD: assert property (@(posedge clk) disable iff (!clr_n)
        !load_n |=> q == $past(din)); // R3

    AST_COUNT_ADVANCES: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && cnt_en_p && cnt_en_t) |=> q == after_step($past(q))); // R1

    AST_HOLD_WHEN_GATED: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && !(cnt_en_p && cnt_en_t)) |=> $stable(q)); // R1

    AST_CARRY_NEEDS_T: assert property (@(posedge clk) disable iff (!clr_n)
        carry_out |-> cnt_en_t); // R2

    AST_CARRY_AT_TERM: assert property (@(posedge clk) disable iff (!clr_n)
        carry_out |-> q == TERM); // R2

    AST_TERM_RAISES_CARRY: assert property (@(posedge clk) disable iff (!clr_n)
        (cnt_en_t && q == TERM) |-> carry_out); // R2

endmodule

bind sync_preset_counter sync_preset_counter_chk #(
    .WIDTH  (WIDTH),
    .DECADE (DECADE)
) u_chk (
    .clk       (clk),
    .clr_n     (clr_n),
    .load_n    (load_n),
    .din       (din),
    .cnt_en_p  (cnt_en_p),
    .cnt_en_t  (cnt_en_t),
    .q         (q),
    .carry_out (carry_out)
);

// File: tb/sync_preset_counter_tb_lane.sv
`timescale 1ns/1ps
module sync_preset_counter_tb_lane #(
    parameter bit          DECADE   = 1'b1,
    parameter bit          SYNC_CLR = 1'b1,
    parameter int unsigned SEED     = 1
) (
    input  logic clk,
    output logic done,
    output int   n_chk,
    output int   n_bad
);

    localparam logic [3:0] TERM = DECADE ? 4'd9 : 4'd15;

    logic       clr_n, load_n, enp, ent, carry;
    logic [3:0] din, q;
    logic [3:0] exp_q;

    sync_preset_counter #(
        .WIDTH      (4),
        .DECADE     (DECADE),
        .SYNC_CLEAR (SYNC_CLR)
    ) dut_i (
        .clk       (clk),
        .clr_n     (clr_n),
        .load_n    (load_n),
        .din       (din),
        .cnt_en_p  (enp),
        .cnt_en_t  (ent),
        .q         (q),
        .carry_out (carry)
    );

    function automatic logic [3:0] model_next(input logic [3:0] cur, input logic c,
                                              input logic l, input logic [3:0] d,
                                              input logic p, input logic t);
        if (!c)           return 4'd0;
        else if (!l)      return d;
        else if (p && t)  return (cur == TERM) ? 4'd0 : cur + 4'd1;
        else              return cur;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s (decade=%0d sync=%0d) actual=%0d expected=%0d",
                     tag, DECADE, SYNC_CLR, act, expv);
        end
    endtask

    task automatic step(input logic c, input logic l, input logic [3:0] d,
                        input logic p, input logic t, input string tag);
        @(negedge clk);
        clr_n = c; load_n = l; din = d; enp = p; ent = t;
        #1;
        if (!c && !SYNC_CLR)
            chk(q == 4'd0, "R5 immediate clear", int'(q), 0);
        if (!c && SYNC_CLR)
            chk(q == exp_q, "R4 no change before edge", int'(q), int'(exp_q));
        @(posedge clk);
        exp_q = model_next(exp_q, c, l, d, p, t);
        #1;
        chk(q == exp_q, tag, int'(q), int'(exp_q));
        chk(carry == ((exp_q == TERM) && t), "R2 carry flag", int'(carry),
            int'((exp_q == TERM) && t));
    endtask

    initial begin
        logic [3:0] seq [6];
        logic [3:0] pre;
        n_chk = 0; n_bad = 0; done = 1'b0;
        clr_n = 1'b0; load_n = 1'b1; din = 4'd0; enp = 1'b0; ent = 1'b0;
        exp_q = 4'd0;
        void'($urandom(SEED));

        // Reset state through clear
        step(1'b0, 1'b1, 4'd0, 1'b0, 1'b0, "R4/R5 reset state");

        // R10 reference sequence
        pre = DECADE ? 4'd7 : 4'd12;
        if (DECADE) seq = '{4'd8, 4'd9, 4'd0, 4'd1, 4'd2, 4'd3};
        else        seq = '{4'd13, 4'd14, 4'd15, 4'd0, 4'd1, 4'd2};
        step(1'b0, 1'b1, 4'd0, 1'b1, 1'b1, "R10 clear");
        step(1'b1, 1'b0, pre, 1'b0, 1'b0, "R10 preset");
        chk(q == pre, "R10 preset value", int'(q), int'(pre));
        for (int i = 0; i < 6; i++) begin
            step(1'b1, 1'b1, 4'd0, 1'b1, 1'b1, "R10 count");
            chk(q == seq[i], "R10 sequence", int'(q), int'(seq[i]));
        end
        step(1'b1, 1'b1, 4'd0, 1'b1, 1'b0, "R10 inhibit by t");
        chk(q == seq[5], "R10 inhibit holds", int'(q), int'(seq[5]));
        step(1'b1, 1'b1, 4'd0, 1'b0, 1'b1, "R1 inhibit by p");
        chk(q == seq[5], "R1 hold value", int'(q), int'(seq[5]));

        // R2: permit p has no effect on flag at terminal
        step(1'b1, 1'b0, TERM, 1'b0, 1'b1, "R3 load terminal");
        chk(carry == 1'b1, "R2 flag with p low", int'(carry), 1);
        step(1'b1, 1'b1, 4'd0, 1'b1, 1'b0, "R2 hold at terminal");
        chk(carry == 1'b0, "R2 flag needs t", int'(carry), 0);

        // R8 wrap from terminal
        step(1'b1, 1'b1, 4'd0, 1'b1, 1'b1, "R8 wrap");
        chk(q == 4'd0, "R8 wrap value", int'(q), 0);

        // R3 load ignoring enables, R7 load beats count, R6 clear beats load
        step(1'b1, 1'b0, 4'd6, 1'b0, 1'b0, "R3 load");
        chk(q == 4'd6, "R3 load value", int'(q), 6);
        step(1'b1, 1'b0, 4'd3, 1'b1, 1'b1, "R7 load over count");
        chk(q == 4'd3, "R7 load value", int'(q), 3);
        step(1'b0, 1'b0, 4'd5, 1'b1, 1'b1, "R6 clear over load");
        chk(q == 4'd0, "R6 clear value", int'(q), 0);

        // R5 held clear across edges
        step(1'b1, 1'b0, 4'd4, 1'b0, 1'b0, "R3 load");
        step(1'b0, 1'b1, 4'd0, 1'b1, 1'b1, "R5/R4 clear");
        step(1'b0, 1'b1, 4'd0, 1'b1, 1'b1, "R5/R4 clear held");

        // R9 out-of-range in decimal mode
        if (DECADE) begin
            step(1'b1, 1'b0, 4'd12, 1'b0, 1'b1, "R9 load 12");
            for (int i = 0; i < 4; i++) begin
                step(1'b1, 1'b1, 4'd0, 1'b1, 1'b1, "R9 count past range");
                chk(carry == 1'b0 || q == 4'd9, "R9 no flag out of range", int'(carry), 0);
            end
            chk(q == 4'd0, "R9 reaches zero", int'(q), 0);
        end

        // R11 count truncation via decode feedback
        if (SYNC_CLR) begin
            step(1'b0, 1'b1, 4'd0, 1'b1, 1'b1, "R11 start");
            for (int i = 0; i < 8; i++) begin
                logic was5;
                was5 = (q == 4'd5);
                step(!was5, 1'b1, 4'd0, 1'b1, 1'b1, "R11 truncated count");
                if (was5)
                    chk(q == 4'd0, "R11 back to zero", int'(q), 0);
            end
        end

        // Random control stimulus
        for (int i = 0; i < 600; i++) begin
            logic c, l, p, t;
            logic [3:0] d;
            c = ($urandom % 16) != 0;
            l = ($urandom % 8) != 0;
            p = ($urandom % 4) != 0;
            t = ($urandom % 4) != 0;
            d = 4'($urandom);
            step(c, l, d, p, t, "R1/R3/R6/R7/R8 random");
        end

        done = 1'b1;
    end

endmodule

// File: tb/sync_preset_counter_tb_top.sv
`timescale 1ns/1ps
module sync_preset_counter_tb_top;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic done_a [4];
    int   chk_a  [4];
    int   bad_a  [4];

    generate
        for (genvar g = 0; g < 4; g++) begin : lane
            sync_preset_counter_tb_lane #(
                .DECADE   (1'((g >> 0) & 1)),
                .SYNC_CLR (1'((g >> 1) & 1)),
                .SEED     (32'd1234 + g)
            ) lane_i (
                .clk   (clk),
                .done  (done_a[g]),
                .n_chk (chk_a[g]),
                .n_bad (bad_a[g])
            );
        end
    endgenerate

    initial begin
        int cyc;
        int total;
        int bad;
        bit all_done;
        cyc = 0;
        all_done = 1'b0;
        while (!all_done && cyc < 150000) begin
            @(posedge clk);
            cyc++;
            all_done = done_a[0] && done_a[1] && done_a[2] && done_a[3];
        end
        #2;
        total = 0;
        bad   = 0;
        for (int i = 0; i < 4; i++) begin
            total += chk_a[i];
            bad   += bad_a[i];
        end
        if (!all_done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not complete actual=%0d expected=done", cyc);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule